// File: doc/BRIEF.md
# Linear Array Readout Sequencer

This block is a digital model of the timing logic inside a line-scan image sensor with `NUM_PIX` photosites (64 by default). Only a clock and a start pulse drive it. A start pulse that is seen at a rising clock edge while the block is idle begins a readout frame. In that frame, a single active bit walks through a select vector, one position per rising edge, so each photosite is connected in turn to the shared analog output stage.

The block also produces the control signals for the analog stage. The output-enable stands in for the tri-state control of the analog output, and the pixel index reports which element is being driven. The sense-node reset and the sample/hold control are derived from the clock phase and never overlap.

Each frame lasts exactly `NUM_PIX` + 1 rising edges. The final edge ends the last pixel, turns the output off and empties the chain. Start pulses that arrive during a frame are ignored, so a frame always runs to completion. A start pulse on the very next edge after the frame ends begins a new frame at once, which gives back-to-back frames.

Top module: `line_scan_sequencer`

## Requirements
- R1: While `rst_ni` is low, `pixel_sel_o` is all zero, and `pixel_idx_o`, `out_en_o`, `busy_o`, `sample_o` and `node_rst_o` are all 0.
- R2: When `start_i` is 1 at a rising edge while the block is idle (`busy_o` = 0), then after that edge `pixel_sel_o` has only bit 0 set (pixel 1), `pixel_idx_o` = 0 and `out_en_o` = 1.
- R3: After the k-th rising edge of a frame, counting the start edge as edge 1, `pixel_sel_o` has only bit k-1 set and `pixel_idx_o` = k-1, for every k from 1 to 64.
- R4: The 65th rising edge of a frame clears `pixel_sel_o` to all zero and drives `out_en_o` and `busy_o` to 0.
- R5: In each frame, `out_en_o` is 1 for exactly 64 consecutive cycles. At all times `out_en_o` and `busy_o` are 1 exactly when `pixel_sel_o` is non-zero.
- R6: A `start_i` of 1 at rising edges 2 through 65 of a frame is ignored. The walk of the select bit is the same as in a frame without it.
- R7: A `start_i` of 1 at the 66th rising edge after a start begins a new frame at that edge, with pixel 1 selected.
- R8: `pixel_sel_o` never has more than one bit set. While `out_en_o` is 1, the bit of `pixel_sel_o` at position `pixel_idx_o` is set. While idle, `pixel_idx_o` = 0.
- R9: Out of reset, `sample_o` is 1 while the clock is high, and `node_rst_o` is 1 while the clock is low. The two outputs are never 1 at the same time.
- R10: Pulling `rst_ni` low during a frame clears the frame at once. After reset is released, a start pulse begins a normal frame from pixel 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shift clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled at the rising edge |
| pixel_sel_o | output | NUM_PIX | One-hot select of the pixel being read out |
| pixel_idx_o | output | $clog2(NUM_PIX) | Zero-based index of the selected pixel |
| node_rst_o | output | 1 | Sense-node reset, high in the clock-low phase |
| sample_o | output | 1 | Sample (1) or hold (0) control, follows the clock-high phase |
| out_en_o | output | 1 | Analog output enable (0 = high impedance) |
| busy_o | output | 1 | Frame in progress |

## Verification
A corrupted chain shows up at the ports on the very next rising edge, in one of three ways:
- a second set bit, or a gap, in `pixel_sel_o`;
- a `pixel_idx_o` that does not step by one;
- a change in `out_en_o` at the wrong time.

An error in the idle gating shows up differently: a frame restarts, or a pixel is skipped, in the cycle right after a start pulse that came in mid-frame. An error in the termination logic shows up as an enable window other than 64 cycles long. That error appears by edge 65 of the first frame at the latest.

// File: rtl/lss_pkg.sv
package lss_pkg;
  localparam int unsigned DEF_NUM_PIX = 64;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/lss_shift_chain.sv
module lss_shift_chain #(
  parameter int unsigned NUM_PIX = lss_pkg::DEF_NUM_PIX
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  output logic [NUM_PIX-1:0] chain_o
);
  logic [NUM_PIX-1:0] chain_q;

  // bit 0 is loaded by the accepted start; the top bit falls off on the terminating edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[NUM_PIX-2:0], load_i};
  end

  assign chain_o = chain_q;
endmodule

// File: rtl/lss_index_enc.sv
module lss_index_enc #(
  parameter int unsigned NUM_PIX = lss_pkg::DEF_NUM_PIX,
  localparam int unsigned IDXW   = lss_pkg::idx_width(NUM_PIX)
) (
  input  logic [NUM_PIX-1:0] onehot_i,
  output logic [IDXW-1:0]    idx_o
);
  // OR-tree per index bit; valid for one-hot or zero input
  for (genvar b = 0; b < IDXW; b++) begin : g_bit
    logic acc;
    always_comb begin
      acc = 1'b0;
      for (int i = 0; i < NUM_PIX; i++) begin
        if (((i >> b) & 1) != 0) acc = acc | onehot_i[i];
      end
    end
    assign idx_o[b] = acc;
  end
endmodule

// File: rtl/lss_phase_gen.sv
module lss_phase_gen (
  input  logic clk_i,
  input  logic rst_ni,
  output logic sample_o,
  output logic node_rst_o
);
  // complementary phases of the clock, both forced low in reset
  assign sample_o   = clk_i & rst_ni;
  assign node_rst_o = ~clk_i & rst_ni;
endmodule

// File: rtl/line_scan_sequencer.sv
module line_scan_sequencer #(
  parameter int unsigned NUM_PIX = lss_pkg::DEF_NUM_PIX,
  localparam int unsigned IDXW   = lss_pkg::idx_width(NUM_PIX)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  output logic [NUM_PIX-1:0] pixel_sel_o,
  output logic [IDXW-1:0]    pixel_idx_o,
  output logic               node_rst_o,
  output logic               sample_o,
  output logic               out_en_o,
  output logic               busy_o
);
  logic [NUM_PIX-1:0] chain;
  logic               active;
  logic               load;

  assign active = |chain;
  // start only accepted once the chain has fully drained
  assign load   = start_i & ~active;

  lss_shift_chain #(.NUM_PIX(NUM_PIX)) u_chain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .chain_o (chain)
  );

  lss_index_enc #(.NUM_PIX(NUM_PIX)) u_enc (
    .onehot_i (chain),
    .idx_o    (pixel_idx_o)
  );

  lss_phase_gen u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sample_o   (sample_o),
    .node_rst_o (node_rst_o)
  );

  assign pixel_sel_o = chain;
  assign out_en_o    = active;
  assign busy_o      = active;
endmodule

// File: rtl/lss_checker.sv
module lss_checker #(
  parameter int unsigned NUM_PIX = lss_pkg::DEF_NUM_PIX,
  localparam int unsigned IDXW   = lss_pkg::idx_width(NUM_PIX)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic [NUM_PIX-1:0] pixel_sel_o,
  input logic [IDXW-1:0]    pixel_idx_o,
  input logic               node_rst_o,
  input logic               sample_o,
  input logic               out_en_o,
  input logic               busy_o
);
  logic [IDXW:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       run_q <= '0;
    else if (out_en_o) run_q <= run_q + 1'b1;
    else               run_q <= '0;
  end

  // R8
  onehot_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pixel_sel_o));

  // R8
  idx_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_en_o |-> pixel_sel_o[pixel_idx_o]);

  // R2
  start_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (pixel_sel_o[0] && out_en_o));

  // R3
  advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_en_o && !pixel_sel_o[NUM_PIX-1]) |=>
      (out_en_o && pixel_idx_o == IDXW'($past(pixel_idx_o) + 1'b1)));

  // R4
  frame_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pixel_sel_o[NUM_PIX-1] |=> !out_en_o);

  // R6
  ignore_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o) |=> !pixel_sel_o[0]);

  // R5
  window_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(out_en_o) |-> (run_q == (IDXW+1)'(NUM_PIX)));

  // R9
  always_comb begin
    phase_overlap_chk: assert (!(sample_o && node_rst_o));
  end
endmodule

bind line_scan_sequencer lss_checker #(.NUM_PIX(NUM_PIX)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .pixel_sel_o (pixel_sel_o),
  .pixel_idx_o (pixel_idx_o),
  .node_rst_o  (node_rst_o),
  .sample_o    (sample_o),
  .out_en_o    (out_en_o),
  .busy_o      (busy_o)
);

// File: tb/line_scan_sequencer_tb.sv
`timescale 1ns/1ps
module line_scan_sequencer_tb;
  localparam int N    = 64;
  localparam int IDXW = 6;
  localparam real HALF = 2.5;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [N-1:0]  pixel_sel_o;
  logic [IDXW-1:0] pixel_idx_o;
  logic          node_rst_o, sample_o, out_en_o, busy_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(HALF) clk_i = ~clk_i;

  line_scan_sequencer #(.NUM_PIX(N)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .pixel_sel_o(pixel_sel_o), .pixel_idx_o(pixel_idx_o),
    .node_rst_o(node_rst_o), .sample_o(sample_o),
    .out_en_o(out_en_o), .busy_o(busy_o)
  );

  task automatic chk(input bit ok, input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(pixel_sel_o == '0, req, pixel_sel_o, '0);
    chk(out_en_o == 1'b0 && busy_o == 1'b0, req, {out_en_o, busy_o}, 0);
    chk(pixel_idx_o == '0, req, N'(pixel_idx_o), 0);
  endtask

  task automatic chk_pixel(input int k, input string req);
    logic [N-1:0] exp = N'(1) << (k - 1);
    chk(pixel_sel_o == exp, req, pixel_sel_o, exp);
    chk(pixel_idx_o == IDXW'(k - 1), req, N'(pixel_idx_o), N'(k - 1));
    chk(out_en_o && busy_o, req, {out_en_o, busy_o}, 3);
  endtask

  // R1: state while reset held
  task automatic t_reset();
    rst_ni = 1'b0;
    start_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk_idle("R1");
    chk(sample_o == 1'b0 && node_rst_o == 1'b0, "R1", {sample_o, node_rst_o}, 0);
    @(posedge clk_i); #1;
    chk(sample_o == 1'b0, "R1", N'(sample_o), 0);
    @(negedge clk_i);
    start_i = 1'b0;
    rst_ni  = 1'b1;
    @(negedge clk_i);
    chk_idle("R1");
  endtask

  // R2 R3 R4 R5 R6 R7: one frame; optional start held throughout
  task automatic t_frame(input bit keep_start);
    int oe_cnt = 0;
    string rq;
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i);
    if (!keep_start) start_i = 1'b0;
    chk_pixel(1, "R2");
    for (int k = 1; k <= N; k++) begin
      rq = keep_start ? "R6" : "R3";
      chk_pixel(k, rq);
      if (out_en_o) oe_cnt++;
      @(negedge clk_i);
    end
    if (keep_start) begin
      // start still high at edge 66: new frame
      chk(pixel_sel_o == '0 && !out_en_o, "R4", pixel_sel_o, '0);
      @(negedge clk_i);
      start_i = 1'b0;
      chk_pixel(1, "R7");
      for (int k = 2; k <= N + 1; k++) @(negedge clk_i);
      chk_idle("R7");
    end else begin
      chk_idle("R4");
      chk(oe_cnt == N, "R5", N'(oe_cnt), N'(N));
    end
  endtask

  // R5: quiet line stays idle
  task automatic t_quiet();
    start_i = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_i);
      chk_idle("R5");
    end
  endtask

  // R9: clock-phase outputs
  task automatic t_phase();
    for (int i = 0; i < 4; i++) begin
      @(posedge clk_i); #1;
      chk(sample_o == 1'b1 && node_rst_o == 1'b0, "R9", {sample_o, node_rst_o}, 2);
      @(negedge clk_i); #1;
      chk(sample_o == 1'b0 && node_rst_o == 1'b1, "R9", {sample_o, node_rst_o}, 1);
    end
  endtask

  // R10: reset mid-frame then clean frame
  task automatic t_abort();
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    repeat (9) @(negedge clk_i);
    chk_pixel(10, "R10");
    rst_ni = 1'b0;
    #1;
    chk_idle("R10");
    @(negedge clk_i) rst_ni = 1'b1;
    @(negedge clk_i);
    chk_idle("R10");
    t_frame(1'b0);
  endtask

  initial begin
    #(HALF * 2 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_quiet();
    t_frame(1'b0);
    t_frame(1'b1);
    t_phase();
    t_abort();
    t_quiet();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule